// File: doc/BRIEF.md
# Command/Indicate Channel Persistence Filter

This block handles the small command/indicate code that a framed line carries in every frame. In the transmit direction it holds a local indication register. The frame assembler picks up its content in every frame, so the far end sees the same code over and over until local logic writes a new one. Only a write to that register changes what goes out.

In the receive direction the frame disassembler presents the incoming code together with a one-cycle frame strobe. The block keeps a short history of the codes it has received. It copies a code into the local control register only when the same code has arrived in a set number of back-to-back frames. The default is two. It also refuses any code that equals the value already held. Each accepted change raises a one-cycle event beside the new value. A single corrupted frame therefore never reaches the control logic. What the codes mean, and the state machine they drive, belong to other blocks.

Top module: `cmdind_filter`

## Requirements
- R1: After reset, tx_code and ctrl_code both read 4'b1111 and ctrl_chg is 0.
- R2: When ind_wr is 1 at a clock edge, tx_code takes ind_wdata from the next cycle on. Without a write, tx_code holds its value.
- R3: tx_code is not affected by frame_stb or rx_code. The same code is offered in every frame until the next write.
- R4: A code that differs from ctrl_code and is presented with frame_stb in two consecutive frames is loaded into ctrl_code. The load happens at the clock edge of the second strobe.
- R5: The receive history is cleared by reset. The first frame after reset cannot complete a match, so a single frame never changes ctrl_code.
- R6: A one-frame glitch to another code, followed by a return to the held code, leaves ctrl_code unchanged and raises no event.
- R7: A received code equal to the current ctrl_code causes no update and no event, however many frames repeat it.
- R8: ctrl_chg is high for exactly one cycle, in the same cycle that ctrl_code first shows the new value. ctrl_code never changes while ctrl_chg is low.
- R9: rx_code is ignored in cycles where frame_stb is 0. It neither counts as a frame nor disturbs the match history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| frame_stb | input | 1 | One-cycle pulse: rx_code holds this frame's received code |
| rx_code | input | 4 | Received command/indicate code |
| ind_wr | input | 1 | Write enable for the indication register |
| ind_wdata | input | 4 | New indication code |
| tx_code | output | 4 | Code to send in every frame |
| ctrl_code | output | 4 | Filtered control register |
| ctrl_chg | output | 1 | One-cycle pulse on each accepted change |

## Verification
The assertions take for granted that frame strobes are at least two cycles apart, as any real frame period guarantees. With that spacing the one-cycle-pulse property and the check that each event follows a strobe are meaningful. The bench meets this by spacing its frames with idle cycles. In those idle cycles it drives junk codes on rx_code to show that the input is sampled only under the strobe. Index writes are driven in the same way at any time, because the transmit side has no timing assumption.

// File: rtl/cmdind_pkg.sv
package cmdind_pkg;

  // Next length of the run of identical frames.
  // A frame that repeats the last one extends the run, up to the cap.
  // Any other frame starts a new run of length one.
  function automatic int unsigned run_next(input int unsigned run,
                                           input bit same,
                                           input int unsigned cap);
    if (!same) return 1;
    if (run >= cap) return cap;
    return run + 1;
  endfunction

  // A run of the required length that carries a new code is accepted.
  function automatic bit accept(input int unsigned run,
                                input int unsigned need,
                                input bit differs);
    return (run >= need) && differs;
  endfunction

endpackage

// File: rtl/cmdind_tx_reg.sv
module cmdind_tx_reg #(
  parameter int unsigned CODE_W = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  code_q <= RESET_CODE;
    else if (wr) code_q <= wdata;
  end

  // The register content is offered in every frame.
  assign code = code_q;
endmodule

// File: rtl/cmdind_rx_filter.sv
module cmdind_rx_filter
  import cmdind_pkg::*;
#(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned PERSIST = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [CODE_W-1:0] rx_code,
  output logic [CODE_W-1:0] ctrl_code,
  output logic              ctrl_chg,
  output logic              accept_evt
);
  localparam int unsigned RUN_W = $clog2(PERSIST + 1);

  logic [CODE_W-1:0] last_q;
  logic [RUN_W-1:0]  run_q;
  logic [RUN_W-1:0]  run_nx;
  logic [CODE_W-1:0] ctrl_q;
  logic              chg_q;
  logic              same;

  // A run of zero means no history, so nothing can match yet.
  assign same   = (run_q != '0) && (rx_code == last_q);
  assign run_nx = RUN_W'(run_next(int'(run_q), same, PERSIST));

  assign accept_evt = frame_stb &&
                      accept(int'(run_nx), PERSIST, rx_code != ctrl_q);

  // Match history: updated only on a frame strobe.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= RESET_CODE;
      run_q  <= '0;
    end else if (frame_stb) begin
      last_q <= rx_code;
      run_q  <= run_nx;
    end
  end

  // Control register and its change pulse.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= RESET_CODE;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= accept_evt;
      if (accept_evt) ctrl_q <= rx_code;
    end
  end

  assign ctrl_code = ctrl_q;
  assign ctrl_chg  = chg_q;
endmodule

// File: rtl/cmdind_filter.sv
module cmdind_filter #(
  parameter int unsigned CODE_W  = 4,
  parameter int unsigned PERSIST = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [CODE_W-1:0] rx_code,
  input  logic              ind_wr,
  input  logic [CODE_W-1:0] ind_wdata,
  output logic [CODE_W-1:0] tx_code,
  output logic [CODE_W-1:0] ctrl_code,
  output logic              ctrl_chg
);
  // Internal event, named for the checker.
  logic accept_evt;

  cmdind_tx_reg #(
    .CODE_W(CODE_W),
    .RESET_CODE(RESET_CODE)
  ) u_tx (
    .clk(clk),
    .rst_n(rst_n),
    .wr(ind_wr),
    .wdata(ind_wdata),
    .code(tx_code)
  );

  cmdind_rx_filter #(
    .CODE_W(CODE_W),
    .PERSIST(PERSIST),
    .RESET_CODE(RESET_CODE)
  ) u_rx (
    .clk(clk),
    .rst_n(rst_n),
    .frame_stb(frame_stb),
    .rx_code(rx_code),
    .ctrl_code(ctrl_code),
    .ctrl_chg(ctrl_chg),
    .accept_evt(accept_evt)
  );
endmodule

// File: rtl/cmdind_filter_chk.sv
module cmdind_filter_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic [CODE_W-1:0] rx_code,
  input logic              ind_wr,
  input logic [CODE_W-1:0] ind_wdata,
  input logic [CODE_W-1:0] tx_code,
  input logic [CODE_W-1:0] ctrl_code,
  input logic              ctrl_chg,
  input logic              accept_evt
);
  // R2: a write lands in the next cycle.
  p_tx_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ind_wr |=> tx_code == $past(ind_wdata));

  // R2/R3: without a write the transmit code holds.
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_wr |=> $stable(tx_code));

  // R8: the control code changes only together with the event.
  p_ctrl_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_chg |-> $stable(ctrl_code));

  // R8: the event lasts one cycle (strobes at least two cycles apart).
  p_chg_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_chg |=> !ctrl_chg);

  // R4/R9: an event follows a strobe and carries the strobed code.
  p_chg_from_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_chg |-> $past(frame_stb) && ctrl_code == $past(rx_code));

  // R7: an event always brings a different value.
  p_chg_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_chg |-> ctrl_code != $past(ctrl_code));

  // R9: the internal acceptance fires only under a strobe.
  p_accept_stb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> frame_stb);
endmodule

bind cmdind_filter cmdind_filter_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .frame_stb(frame_stb),
  .rx_code(rx_code),
  .ind_wr(ind_wr),
  .ind_wdata(ind_wdata),
  .tx_code(tx_code),
  .ctrl_code(ctrl_code),
  .ctrl_chg(ctrl_chg),
  .accept_evt(accept_evt)
);

// File: tb/cmdind_filter_tb.sv
module cmdind_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [3:0] rx_code = 4'h0;
  logic       ind_wr = 1'b0;
  logic [3:0] ind_wdata = 4'h0;
  logic [3:0] tx_code;
  logic [3:0] ctrl_code;
  logic       ctrl_chg;

  int n_chk  = 0;
  int n_fail = 0;

  // Model: value the bench expects in the control register.
  logic [3:0] exp_ctrl = 4'hF;
  logic       saw_chg;

  always #10 clk = ~clk;

  cmdind_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rx_code(rx_code),
    .ind_wr(ind_wr), .ind_wdata(ind_wdata), .tx_code(tx_code),
    .ctrl_code(ctrl_code), .ctrl_chg(ctrl_chg)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_ctrl = 4'hF;
  endtask

  // Present one frame, then idle with junk on rx_code (R9).
  // saw_chg records ctrl_chg in the cycle after the strobe edge.
  task automatic frame(input logic [3:0] code);
    @(negedge clk);
    rx_code = code; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0; rx_code = ~code;
    saw_chg = ctrl_chg;
    check("R8 value with event", {4'h0, ctrl_code}, saw_chg ? {4'h0, code} : {4'h0, exp_ctrl});
    if (saw_chg) exp_ctrl = code;
    @(negedge clk);
    rx_code = code ^ 4'h5;
    check("R8 pulse one cycle", {7'h0, ctrl_chg}, 8'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 tx_code", {4'h0, tx_code}, 8'h0F);
    check("R1 ctrl_code", {4'h0, ctrl_code}, 8'h0F);
    check("R1 ctrl_chg", {7'h0, ctrl_chg}, 8'h0);
  endtask

  task automatic t_tx();
    for (int i = 0; i < 3; i++) begin
      logic [3:0] v;
      v = 4'(3 * i + 2);
      @(negedge clk); ind_wr = 1'b1; ind_wdata = v;
      @(negedge clk); ind_wr = 1'b0; ind_wdata = ~v;
      check("R2 write", {4'h0, tx_code}, {4'h0, v});
      repeat (3) @(negedge clk);
      check("R2 hold", {4'h0, tx_code}, {4'h0, v});
    end
    // R3: frames do not disturb the transmit code.
    frame(4'h1); frame(4'h1);
    check("R3 tx untouched by rx", {4'h0, tx_code}, 8'h08);
  endtask

  task automatic t_first_frame();
    do_reset();
    frame(4'h3);
    check("R5 first frame no event", {7'h0, saw_chg}, 8'h0);
    check("R5 first frame no update", {4'h0, ctrl_code}, 8'h0F);
    frame(4'h3);
    check("R4 second frame event", {7'h0, saw_chg}, 8'h1);
    check("R4 second frame value", {4'h0, ctrl_code}, 8'h03);
  endtask

  task automatic t_glitch();
    frame(4'h3);
    frame(4'hA);
    check("R6 glitch no event", {7'h0, saw_chg}, 8'h0);
    frame(4'h3);
    check("R6 return no event", {7'h0, saw_chg}, 8'h0);
    check("R6 value kept", {4'h0, ctrl_code}, 8'h03);
    // Alternating codes never complete a run.
    frame(4'h6); frame(4'h9); frame(4'h6);
    check("R6 alternating kept", {4'h0, ctrl_code}, 8'h03);
  endtask

  task automatic t_same();
    for (int i = 0; i < 4; i++) begin
      frame(4'h3);
      check("R7 repeat no event", {7'h0, saw_chg}, 8'h0);
    end
    frame(4'hC); frame(4'hC);
    check("R4 new code accepted", {4'h0, ctrl_code}, 8'h0C);
    frame(4'hC);
    check("R7 third repeat no event", {7'h0, saw_chg}, 8'h0);
  endtask

  task automatic t_ignore();
    // Between the strobes, rx_code is held at a different code for many cycles.
    frame(4'h5);
    @(negedge clk); rx_code = 4'h7;
    repeat (5) @(negedge clk);
    check("R9 no event between strobes", {7'h0, ctrl_chg}, 8'h0);
    frame(4'h5);
    check("R9 history intact, accepted", {4'h0, ctrl_code}, 8'h05);
  endtask

  initial begin
    t_reset();
    t_tx();
    t_first_frame();
    t_glitch();
    t_same();
    t_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule